// File: doc/BRIEF.md
# Phase-Gated Constant Gain Multiplier

This block multiplies a signed fixed-point input sample by a gain that is fixed at elaboration time. The gain is given as a real number. It is turned into a bit pattern in one of three number formats: signed integer, signed fractional or unsigned integer. The product keeps full precision and leaves through zero or more pipeline registers.

When at least one register stage exists, a short repeating bit pattern decides on which clock cycles the stages take new data. This lets the block keep one sample out of every few, or pick one phase out of an interleaved stream. Two optional controls apply only to the registered form:

- a clock enable, which freezes both the pipeline and the phase position;
- an asynchronous clear.

Top module: `const_gain_scaler`

## Requirements
- R1: The gain code is floor(GAIN_VALUE × 2^F), where F is the effective gain fraction width. Only its low GAIN_W = GAIN_INT + F bits are kept, so values out of range wrap. The code is read as two's complement for both signed formats and as unsigned for the unsigned integer format.
- R2: GAIN_FRAC sets F only in the signed fractional format. In the signed and unsigned integer formats F is 0, whatever GAIN_FRAC holds.
- R3: dout is the exact two's complement product of the signed input code and the gain code. It is IN_W + GAIN_W bits wide, and its binary point sits IN_FRAC + F bits from the right.
- R4: With STAGES = 0 the path is purely combinational (dout follows din at once), and neither ena nor aclr has any effect.
- R5: PHASE_MASK is PHASE_LEN bits wide, and its most significant bit belongs to phase 1. The phase position starts at phase 1 after clear, advances by one on each stepping clock, and returns to phase 1 after phase PHASE_LEN.
- R6: With STAGES ≥ 1 the stages load only on a stepping clock whose current phase bit is 1. Stage 1 then takes the new product and every later stage takes the value of the stage before it. On all other clocks every stage holds its value.
- R7: With USE_ENA = 1 a clock steps only while ena is high. With USE_ENA = 0 ena is ignored and every clock steps.
- R8: With USE_ACLR = 1 a high aclr at once forces every stage and the phase position to zero, without waiting for a clock edge. dout reads 0 while aclr is high.
- R9: A sample reaches dout after exactly STAGES load events, counted from the load event that captures it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| aclr | input | 1 | Asynchronous clear, active high (used when USE_ACLR = 1 and STAGES ≥ 1) |
| ena | input | 1 | Clock enable (used when USE_ENA = 1 and STAGES ≥ 1) |
| din | input | IN_INT+IN_FRAC | Signed fixed-point input sample |
| dout | output | IN_W+GAIN_W | Full-precision signed product |

## Verification
The assertions assume the following about aclr:

- aclr, when it is used, stays high across at least one rising clock edge;
- aclr is never pulsed entirely between two edges, so the hold and restart properties are either disabled or start from a cleared state.

The bench raises aclr a few nanoseconds after an edge and holds it through the next edge. It changes din, ena and aclr only just after rising edges, so the phase position never meets an input that moves at the edge. The combinational form is swept over all input codes while ena and aclr toggle, because its properties place no limits on either control.

// File: rtl/cg_pkg.sv
package cg_pkg;

    // Number format of the constant gain
    typedef enum logic [1:0] {
        GF_SINT  = 2'd0,
        GF_SFRAC = 2'd1,
        GF_UINT  = 2'd2
    } gain_fmt_e;

    // Fraction bits actually carried by the gain for a given format
    function automatic int frac_bits(gain_fmt_e fmt, int frac);
        return (fmt == GF_SFRAC) ? frac : 0;
    endfunction

endpackage

// File: rtl/cg_gain_quant.sv
module cg_gain_quant
    import cg_pkg::*;
#(
    parameter gain_fmt_e FMT    = GF_SFRAC,
    parameter int        G_INT  = 2,
    parameter int        G_FRAC = 3,
    parameter real       VALUE  = 0.75,
    localparam int       F_EFF  = frac_bits(FMT, G_FRAC),
    localparam int       G_W    = G_INT + F_EFF
) (
    output logic [G_W-1:0] gain_o
);

    // Scale to an integer grid, round toward minus infinity, keep low bits
    localparam real         SCALED  = VALUE * (2.0 ** F_EFF);
    localparam longint      FLOORED = longint'($floor(SCALED));
    localparam logic [63:0] FL_BITS = 64'(FLOORED);

    assign gain_o = FL_BITS[G_W-1:0];

endmodule

// File: rtl/cg_mult.sv
module cg_mult #(
    parameter int  X_W      = 5,
    parameter int  G_W      = 5,
    parameter bit  G_SIGNED = 1'b1,
    localparam int P_W      = X_W + G_W
) (
    input  logic [X_W-1:0] x,
    input  logic [G_W-1:0] g,
    output logic [P_W-1:0] p
);

    logic signed [P_W-1:0] x_ext;
    logic signed [P_W-1:0] g_ext;
    logic signed [P_W-1:0] prod;

    assign x_ext = signed'({{G_W{x[X_W-1]}}, x});

    generate
        if (G_SIGNED) begin : g_sgn
            assign g_ext = signed'({{X_W{g[G_W-1]}}, g});
        end else begin : g_uns
            assign g_ext = signed'({{X_W{1'b0}}, g});
        end
    endgenerate

    // The exact product always fits in X_W + G_W bits
    assign prod = x_ext * g_ext;
    assign p    = prod;

endmodule

// File: rtl/cg_phase_seq.sv
module cg_phase_seq #(
    parameter int             LEN  = 4,
    parameter logic [LEN-1:0] MASK = 4'b0100,
    localparam int            CW   = (LEN > 1) ? $clog2(LEN) : 1
) (
    input  logic clk,
    input  logic rst,
    input  logic step,
    output logic load
);

    localparam logic [CW-1:0] LAST = CW'(LEN - 1);

    logic [CW-1:0] phase;

    // Phase position register: index 0 is phase 1
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            phase <= '0;
        end else if (step) begin
            phase <= (phase == LAST) ? '0 : phase + CW'(1);
        end
    end

    // Leftmost mask bit belongs to phase 1
    always_comb begin
        load = step & MASK[(LEN - 1) - int'(phase)];
    end

    a_r5_range: assert property (@(posedge clk) disable iff (rst)
        int'(phase) < LEN);

    a_r5_wrap: assert property (@(posedge clk) disable iff (rst)
        (step && phase == LAST) |=> (phase == '0));

    a_r7_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(phase));

    a_r8_restart: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (phase == '0));

endmodule

// File: rtl/cg_pipe.sv
module cg_pipe #(
    parameter int W      = 10,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    // All stages advance together on a load event
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) begin
                stg[i] <= '0;
            end
        end else if (load) begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];

    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(q));

    a_r9_entry: assert property (@(posedge clk) disable iff (rst)
        load |=> (stg[0] == $past(d)));

endmodule

// File: rtl/const_gain_scaler.sv
module const_gain_scaler
    import cg_pkg::*;
#(
    parameter int                   IN_INT     = 3,
    parameter int                   IN_FRAC    = 2,
    parameter gain_fmt_e            GAIN_FMT   = GF_SFRAC,
    parameter int                   GAIN_INT   = 2,
    parameter int                   GAIN_FRAC  = 3,
    parameter real                  GAIN_VALUE = -1.3,
    parameter int                   STAGES     = 2,
    parameter int                   PHASE_LEN  = 4,
    parameter logic [PHASE_LEN-1:0] PHASE_MASK = 4'b0100,
    parameter bit                   USE_ENA    = 1'b1,
    parameter bit                   USE_ACLR   = 1'b1,
    localparam int                  IN_W       = IN_INT + IN_FRAC,
    localparam int                  GF_EFF     = frac_bits(GAIN_FMT, GAIN_FRAC),
    localparam int                  GAIN_W     = GAIN_INT + GF_EFF,
    localparam int                  OUT_W      = IN_W + GAIN_W
) (
    input  logic             clk,
    input  logic             aclr,
    input  logic             ena,
    input  logic [IN_W-1:0]  din,
    output logic [OUT_W-1:0] dout
);

    localparam bit GAIN_SIGNED = (GAIN_FMT != GF_UINT);

    logic [GAIN_W-1:0] gain;
    logic [OUT_W-1:0]  product;
    logic              step;
    logic              rst;

    assign step = USE_ENA  ? ena  : 1'b1;
    assign rst  = USE_ACLR ? aclr : 1'b0;

    cg_gain_quant #(
        .FMT    (GAIN_FMT),
        .G_INT  (GAIN_INT),
        .G_FRAC (GAIN_FRAC),
        .VALUE  (GAIN_VALUE)
    ) u_quant (
        .gain_o (gain)
    );

    cg_mult #(
        .X_W      (IN_W),
        .G_W      (GAIN_W),
        .G_SIGNED (GAIN_SIGNED)
    ) u_mult (
        .x (din),
        .g (gain),
        .p (product)
    );

    generate
        if (STAGES == 0) begin : g_comb
            logic unused_ctl;
            assign unused_ctl = ^{clk, step, rst};
            assign dout       = product;
        end else begin : g_reg
            logic load;

            cg_phase_seq #(
                .LEN  (PHASE_LEN),
                .MASK (PHASE_MASK)
            ) u_seq (
                .clk  (clk),
                .rst  (rst),
                .step (step),
                .load (load)
            );

            cg_pipe #(
                .W      (OUT_W),
                .STAGES (STAGES)
            ) u_pipe (
                .clk  (clk),
                .rst  (rst),
                .load (load),
                .d    (product),
                .q    (dout)
            );

            a_r7_gate: assert property (@(posedge clk) disable iff (rst)
                !step |-> !load);
        end
    endgenerate

endmodule

// File: tb/test_const_gain_scaler.sv
module test_const_gain_scaler;
    import cg_pkg::*;

    logic       clk = 1'b0;
    logic       aclr, aclr_b;
    logic       ena_a, ena_b, ena_c;
    logic [4:0] din_a, din_b, din_c;
    logic [9:0] dout_a;
    logic [8:0] dout_b;
    logic [7:0] dout_c;

    int n_checks = 0;
    int n_err    = 0;
    bit done     = 0;

    // model state
    int pa, a1, a2;
    int pc, c1;

    always #5 clk = ~clk;

    // A: signed fractional gain -1.3 (code -11), 2 stages, pattern 0100, enable and clear used
    const_gain_scaler #(
        .IN_INT(3), .IN_FRAC(2), .GAIN_FMT(GF_SFRAC), .GAIN_INT(2), .GAIN_FRAC(3),
        .GAIN_VALUE(-1.3), .STAGES(2), .PHASE_LEN(4), .PHASE_MASK(4'b0100),
        .USE_ENA(1'b1), .USE_ACLR(1'b1)
    ) i_const_gain_scaler (
        .clk(clk), .aclr(aclr), .ena(ena_a), .din(din_a), .dout(dout_a)
    );

    // B: signed integer gain -2.6 (code -3), GAIN_FRAC ignored, combinational
    const_gain_scaler #(
        .IN_INT(3), .IN_FRAC(2), .GAIN_FMT(GF_SINT), .GAIN_INT(4), .GAIN_FRAC(5),
        .GAIN_VALUE(-2.6), .STAGES(0), .PHASE_LEN(4), .PHASE_MASK(4'b0100),
        .USE_ENA(1'b1), .USE_ACLR(1'b1)
    ) i_const_gain_scaler_comb (
        .clk(clk), .aclr(aclr_b), .ena(ena_b), .din(din_b), .dout(dout_b)
    );

    // C: unsigned integer gain 11 wrapped to 3 bits (code 3), 1 stage, pattern 10, enable unused
    const_gain_scaler #(
        .IN_INT(3), .IN_FRAC(2), .GAIN_FMT(GF_UINT), .GAIN_INT(3), .GAIN_FRAC(0),
        .GAIN_VALUE(11.0), .STAGES(1), .PHASE_LEN(2), .PHASE_MASK(2'b10),
        .USE_ENA(1'b0), .USE_ACLR(1'b1)
    ) i_const_gain_scaler_dec (
        .clk(clk), .aclr(aclr), .ena(ena_c), .din(din_c), .dout(dout_c)
    );

    function automatic int sx(logic [4:0] v);
        return int'($signed(v));
    endfunction

    task automatic chk(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic model_clear();
        pa = 0; a1 = 0; a2 = 0;
        pc = 0; c1 = 0;
    endtask

    // Drive just after an edge, update the model at the edge, compare 1 ns later
    task automatic run_regs(int n, int seed, string tag_a, string tag_c);
        for (int i = 0; i < n; i++) begin
            din_a = 5'(i * 7 + seed);
            ena_a = ((i % 5) != 3);
            din_c = 5'(i * 11 + seed + 1);
            ena_c = i[0] ^ i[2];
            @(posedge clk);
            if (ena_a) begin
                if (pa == 1) begin
                    a2 = a1;
                    a1 = sx(din_a) * (-11);
                end
                pa = (pa + 1) % 4;
            end
            if (pc == 0) c1 = sx(din_c) * 3;
            pc = (pc + 1) % 2;
            #1;
            chk(tag_a, int'($signed(dout_a)), a2);
            chk(tag_c, int'($signed(dout_c)), c1);
        end
    endtask

    initial begin
        aclr = 1'b1; aclr_b = 1'b0;
        ena_a = 1'b1; ena_b = 1'b1; ena_c = 1'b1;
        din_a = '0; din_b = '0; din_c = '0;
        repeat (3) @(posedge clk);
        #1;
        chk("R8 reset A", int'(dout_a), 0);
        chk("R8 reset C", int'(dout_c), 0);
        aclr = 1'b0;
        model_clear();

        // R5 R6 R7 R9: long run with enable gaps; C ignores its toggling ena
        run_regs(80, 3, "R6/R9 A pipeline", "R7 C ena ignored");

        // R8: clear acts before the next edge
        #3;
        aclr = 1'b1;
        #1;
        chk("R8 async A", int'(dout_a), 0);
        chk("R8 async C", int'(dout_c), 0);
        @(posedge clk);
        #1;
        aclr = 1'b0;
        model_clear();
        // R5: restart at phase 1 after clear
        run_regs(24, 9, "R5 A restart", "R5 C restart");

        // R1 R2 R3: single-code checks of quantized gains
        din_b = 5'd1;
        #1;
        chk("R1 B gain code", int'($signed(dout_b)), -3);
        // R4 R2 R3: exhaustive sweep of the combinational form, controls toggling
        for (int v = 0; v < 32; v++) begin
            din_b  = 5'(v);
            aclr_b = v[0];
            ena_b  = v[1];
            #2;
            chk("R4/R2/R3 B product", int'($signed(dout_b)), sx(5'(v)) * (-3));
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

endmodule